// File: doc/BRIEF.md
# Circularly shifted sequence streamer

This block plays back a periodic binary code from an on-chip sequence memory as a continuous stream of output words, `OUT_W` chips per word. In rotating mode every new pass through the code begins one chip later in the code than the previous pass. A reference stream of the same code and this rotated stream are fed to a correlator, and the lag between them then steps through successive chip positions with no gap in the stream. In fixed mode the code simply repeats, which yields the unrotated reference stream. An optional dwell setting sends each lag twice in a row, so that a downstream filter can settle after every lag change.

The memory is `MEM_W` bits wide and is loaded through a simple write port while the block is idle. Each cycle the block reads two adjacent memory words at once and cuts one output word out of that pair. When a pass ends inside an output word, the same word carries the first chips of the next pass, so the code length does not have to be a multiple of either width. A start trigger marks the first word of a run, and a step trigger marks every word in which a new lag begins. Both triggers are registered with the data word they belong to. One enable input freezes the whole datapath, the triggers included.

Top module: `seqrot_stream`

## Requirements
- R1: With rotation on and dwell off, pass q (counting from 0) carries the chips s[(q+i) mod N] for i = 0..N-1, where N is `seq_len`. Passes follow each other with no gap. Bit 0 of `word_out` is the earliest chip, and word w of a run holds stream chips w*OUT_W through w*OUT_W+OUT_W-1. Linear chip address a is bit a mod MEM_W of memory word a/MEM_W, and the memory must hold s[a mod N] at every address the run reads.
- R2: When a pass has r < OUT_W chips left at the start of a word, the low r bits of that word finish the pass and bit r onward already carries the next pass, starting at its new lag.
- R3: When a pass ends exactly on a word boundary, that word comes wholly from the ending pass and the next lag begins at bit 0 of the following word.
- R4: With rotation on and dwell on, passes 2j and 2j+1 both use lag j, and the run contains 2*`lag_count` passes.
- R5: With rotation off, every pass is the unrotated code, the run contains `lag_count` passes, `dwell` has no effect and `trig_step` is never asserted.
- R6: `trig_lag0` is high together with the first word of a run and with no other word.
- R7: `trig_step` is high exactly on the words that contain the first chip of a pass whose lag differs from the lag of the pass before it.
- R8: After the last pass, the unused high bits of the final word are zero, `busy` is low from the edge that delivers that word, and no further word is produced.
- R9: While `en` is low, no word is produced, no internal state changes and `start` is ignored. The stream then resumes with no chip lost or repeated.
- R10: A start is accepted only while the block is idle, with `lag_count` nonzero and `seq_len` >= OUT_W. A start pulse during a run does not change the stream. `lag_count` must not exceed N.
- R11: During and right after reset, `busy`, `word_valid`, `trig_lag0`, `trig_step` and `word_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; low freezes the block |
| start | input | 1 | Begin a run with the configuration inputs |
| rot_en | input | 1 | 1: rotate one chip per lag; 0: fixed repetition |
| dwell | input | 1 | Send each lag in two consecutive passes (rotating mode) |
| seq_len | input | LW | Code length N in chips |
| lag_count | input | LW | Number of lags (rotating) or passes (fixed) |
| wr_en | input | 1 | Sequence memory write strobe |
| wr_addr | input | AW | Sequence memory word address |
| wr_data | input | MEM_W | Sequence memory write data |
| word_out | output | OUT_W | Output chips, bit 0 earliest |
| word_valid | output | 1 | One pulse per delivered word |
| trig_lag0 | output | 1 | First word of a run (lag zero) |
| trig_step | output | 1 | Word in which a new lag begins |
| busy | output | 1 | A run is in progress |

## Verification
The bench builds the block with OUT_W=16, MEM_W=32 and DEPTH=16. These small widths make runs that sweep every lag of codes from 16 to 100 chips short, and they produce many splices per run. At these sizes a read window crosses a memory-word boundary every few words, and the lengths include multiples of the output width, which hit the exact-boundary case. Codes only slightly longer than one word splice in almost every word, and the dwell, stall and mid-run start cases run on these same short codes. Every word is compared with a bit-array model that rotates the code pass by pass.

// File: rtl/seqrot_pkg.sv
package seqrot_pkg;

    typedef enum logic {
        LAG_FIXED  = 1'b0,
        LAG_ROTATE = 1'b1
    } lag_mode_e;

    // Number of passes that make up one run.
    function automatic int unsigned pass_total(int unsigned steps, logic rotate, logic twice);
        return (rotate && twice) ? steps * 2 : steps;
    endfunction

endpackage

// File: rtl/seqrot_mem.sv
module seqrot_mem #(
    parameter int MEM_W = 256,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [MEM_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [MEM_W-1:0] rd_lo,
    output logic [MEM_W-1:0] rd_hi
);
    logic [MEM_W-1:0] store [DEPTH];
    logic [AW-1:0]    rd_next;

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    // Two independent read ports: the addressed word and its upper neighbour.
    assign rd_next = rd_addr + AW'(1);
    assign rd_lo   = store[rd_addr];
    assign rd_hi   = store[rd_next];
endmodule

// File: rtl/seqrot_ctrl.sv
module seqrot_ctrl
    import seqrot_pkg::*;
#(
    parameter int OUT_W = 80,
    parameter int LW    = 13,
    parameter int PW    = 14,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          start,
    input  logic          rotate,
    input  logic          twice,
    input  logic [LW-1:0] cfg_len,
    input  logic [LW-1:0] cfg_steps,
    output logic          busy,
    output logic [PW-1:0] ptr,
    output logic [CW-1:0] cut,
    output logic          skip,
    output logic [CW-1:0] vlen,
    output logic          tstart,
    output logic          tstep
);
    logic          running;
    lag_mode_e     mode;
    logic          hold;
    logic [LW-1:0] len_q;
    logic [LW-1:0] idx_q;
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] left_q;
    logic          rep_q;
    logic          first_q;
    logic          pend_q;

    logic [LW-1:0] rem;
    logic          ending;
    logic          exact;
    logic          adv;
    logic          last;
    logic          cfg_ok;
    logic [PW-1:0] total;

    assign rem    = len_q - idx_q;
    assign ending = (rem <= LW'(OUT_W));
    assign exact  = (rem == LW'(OUT_W));
    assign adv    = (mode == LAG_ROTATE) && (!hold || rep_q);
    assign last   = (left_q == PW'(1));
    assign cfg_ok = (cfg_steps != '0) && (cfg_len >= LW'(OUT_W));
    assign total  = PW'(pass_total(32'(cfg_steps), rotate, twice));

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            mode    <= LAG_FIXED;
            hold    <= 1'b0;
            len_q   <= '0;
            idx_q   <= '0;
            ptr_q   <= '0;
            left_q  <= '0;
            rep_q   <= 1'b0;
            first_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (en) begin
            if (!running) begin
                if (start && cfg_ok) begin
                    running <= 1'b1;
                    mode    <= rotate ? LAG_ROTATE : LAG_FIXED;
                    hold    <= twice;
                    len_q   <= cfg_len;
                    idx_q   <= '0;
                    ptr_q   <= '0;
                    left_q  <= total;
                    rep_q   <= 1'b0;
                    first_q <= 1'b1;
                    pend_q  <= 1'b0;
                end
            end else begin
                first_q <= 1'b0;
                if (!ending) begin
                    ptr_q  <= ptr_q + PW'(OUT_W);
                    idx_q  <= idx_q + LW'(OUT_W);
                    pend_q <= 1'b0;
                end else if (last) begin
                    running <= 1'b0;
                    pend_q  <= 1'b0;
                end else begin
                    // Continue linearly; one chip is dropped when the lag advances,
                    // then the pointer folds back by one code length.
                    left_q <= left_q - PW'(1);
                    ptr_q  <= ptr_q + PW'(OUT_W) + PW'(adv) - PW'(len_q);
                    idx_q  <= LW'(OUT_W) - rem;
                    rep_q  <= hold ? !rep_q : 1'b0;
                    pend_q <= adv && exact;
                end
            end
        end
    end

    assign busy   = running;
    assign ptr    = ptr_q;
    assign cut    = ending ? CW'(rem) : CW'(OUT_W);
    assign skip   = ending && adv && !last;
    assign vlen   = (ending && last) ? CW'(rem) : CW'(OUT_W);
    assign tstart = first_q;
    assign tstep  = pend_q || (ending && adv && !last && !exact);
endmodule

// File: rtl/seqrot_splice.sv
module seqrot_splice #(
    parameter int OUT_W = 80,
    parameter int MEM_W = 256,
    parameter int CW    = 7,
    localparam int OW   = $clog2(MEM_W),
    localparam int WW   = OUT_W + 1
) (
    input  logic [MEM_W-1:0] lo,
    input  logic [MEM_W-1:0] hi,
    input  logic [OW-1:0]    off,
    input  logic [CW-1:0]    cut,
    input  logic             skip,
    input  logic [CW-1:0]    vlen,
    output logic [OUT_W-1:0] word
);
    // One spare chip above the word so a single dropped chip can be absorbed.
    logic [WW-1:0] win;
    assign win = WW'({hi, lo} >> off);

    for (genvar j = 0; j < OUT_W; j++) begin : g_bit
        localparam logic [CW-1:0] POS = CW'(j);
        assign word[j] = (POS >= vlen) ? 1'b0 :
                         ((POS < cut) || !skip) ? win[j] : win[j+1];
    end
endmodule

// File: rtl/seqrot_stream.sv
module seqrot_stream #(
    parameter int OUT_W = 80,
    parameter int MEM_W = 256,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int OW = $clog2(MEM_W),
    localparam int LW = $clog2(DEPTH * MEM_W) + 1,
    localparam int PW = LW + 1,
    localparam int CW = $clog2(OUT_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start,
    input  logic             rot_en,
    input  logic             dwell,
    input  logic [LW-1:0]    seq_len,
    input  logic [LW-1:0]    lag_count,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [MEM_W-1:0] wr_data,
    output logic [OUT_W-1:0] word_out,
    output logic             word_valid,
    output logic             trig_lag0,
    output logic             trig_step,
    output logic             busy
);
    logic [PW-1:0]    ptr;
    logic [CW-1:0]    cut;
    logic [CW-1:0]    vlen;
    logic             skip;
    logic             tstart;
    logic             tstep;
    logic [MEM_W-1:0] rd_lo;
    logic [MEM_W-1:0] rd_hi;
    logic [AW-1:0]    rd_addr;
    logic [OW-1:0]    rd_off;
    logic [OUT_W-1:0] word;

    assign rd_addr = AW'(ptr >> OW);
    assign rd_off  = OW'(ptr);

    seqrot_ctrl #(.OUT_W(OUT_W), .LW(LW), .PW(PW), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst), .en(en), .start(start),
        .rotate(rot_en), .twice(dwell),
        .cfg_len(seq_len), .cfg_steps(lag_count),
        .busy(busy), .ptr(ptr), .cut(cut), .skip(skip), .vlen(vlen),
        .tstart(tstart), .tstep(tstep)
    );

    seqrot_mem #(.MEM_W(MEM_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_lo(rd_lo), .rd_hi(rd_hi)
    );

    seqrot_splice #(.OUT_W(OUT_W), .MEM_W(MEM_W), .CW(CW)) u_splice (
        .lo(rd_lo), .hi(rd_hi), .off(rd_off),
        .cut(cut), .skip(skip), .vlen(vlen), .word(word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out   <= '0;
            word_valid <= 1'b0;
            trig_lag0  <= 1'b0;
            trig_step  <= 1'b0;
        end else if (en) begin
            word_out   <= busy ? word : '0;
            word_valid <= busy;
            trig_lag0  <= busy && tstart;
            trig_step  <= busy && tstep;
        end else begin
            word_valid <= 1'b0;
            trig_lag0  <= 1'b0;
            trig_step  <= 1'b0;
        end
    end
endmodule

// File: rtl/seqrot_checks.sv
module seqrot_checks (
    input logic clk,
    input logic rst,
    input logic en,
    input logic busy,
    input logic word_valid,
    input logic trig_lag0,
    input logic trig_step
);
    // R11
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !word_valid));

    // R9
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst) !en |=> !word_valid);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(busy));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !busy |=> !word_valid);

    // R6
    lag0_word_chk: assert property (@(posedge clk) disable iff (rst) trig_lag0 |-> word_valid);

    // R7
    step_word_chk: assert property (@(posedge clk) disable iff (rst) trig_step |-> (word_valid && !trig_lag0));
endmodule

bind seqrot_stream seqrot_checks u_checks (
    .clk(clk), .rst(rst), .en(en), .busy(busy),
    .word_valid(word_valid), .trig_lag0(trig_lag0), .trig_step(trig_step)
);

// File: tb/seqrot_stream_bench.sv
module seqrot_stream_bench;
    localparam int OUT_W      = 16;
    localparam int MEM_W      = 32;
    localparam int DEPTH      = 16;
    localparam int AW         = $clog2(DEPTH);
    localparam int LW         = $clog2(DEPTH * MEM_W) + 1;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        int len;
        int steps;
        int seed;
        bit rot;
        bit dwl;
        bit stall;
        bit poke;
    } vec_t;

    // len, lag count, seed, rotate, dwell, stall en, mid-run start
    localparam vec_t VECS [10] = '{
        '{23,  23, 1, 1'b1, 1'b0, 1'b0, 1'b0},   // R1 R2
        '{16,  16, 2, 1'b1, 1'b0, 1'b0, 1'b0},   // R3 every word ends a pass
        '{48,  12, 3, 1'b1, 1'b0, 1'b0, 1'b0},   // R3
        '{37,  10, 4, 1'b1, 1'b1, 1'b0, 1'b0},   // R4
        '{29,   6, 5, 1'b0, 1'b0, 1'b0, 1'b0},   // R5
        '{17,  17, 6, 1'b1, 1'b0, 1'b1, 1'b0},   // R9
        '{100, 40, 7, 1'b1, 1'b0, 1'b0, 1'b0},   // R1 R2
        '{61,  20, 8, 1'b1, 1'b1, 1'b1, 1'b0},   // R4 R9
        '{45,   4, 9, 1'b0, 1'b1, 1'b0, 1'b0},   // R5 dwell ignored
        '{31,  31, 10, 1'b1, 1'b0, 1'b0, 1'b1}   // R10 start during run
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             en;
    logic             start;
    logic             rot_en;
    logic             dwell;
    logic [LW-1:0]    seq_len;
    logic [LW-1:0]    lag_count;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [MEM_W-1:0] wr_data;
    logic [OUT_W-1:0] word_out;
    logic             word_valid;
    logic             trig_lag0;
    logic             trig_step;
    logic             busy;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    bit seqb  [256];
    bit exb   [8192];
    bit stepw [1024];

    always #(CLK_PERIOD / 2) clk = ~clk;

    seqrot_stream #(.OUT_W(OUT_W), .MEM_W(MEM_W), .DEPTH(DEPTH)) u_seqrot_stream (
        .clk(clk), .rst(rst), .en(en), .start(start), .rot_en(rot_en), .dwell(dwell),
        .seq_len(seq_len), .lag_count(lag_count),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .word_out(word_out), .word_valid(word_valid),
        .trig_lag0(trig_lag0), .trig_step(trig_step), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int lag_of(input vec_t v, input int q);
        if (!v.rot) return 0;
        return v.dwl ? q / 2 : q;
    endfunction

    task automatic run_vec(input vec_t v);
        int total;
        int nbits;
        int nwords;
        int k;
        int cyc;
        bit prev_en;
        string tg;
        logic [OUT_W-1:0] expw;

        tg = !v.rot ? "R5" : v.dwl ? "R4" : v.poke ? "R10" :
             ((v.len % OUT_W) == 0) ? "R3" : "R1 R2";

        for (int i = 0; i < v.len; i++)
            seqb[i] = ^(8'((i * 37 + v.seed * 11 + i * i) % 251));

        // Periodic memory image: address a holds s[a mod N]
        for (int w = 0; w < DEPTH; w++) begin
            logic [MEM_W-1:0] wd;
            for (int b = 0; b < MEM_W; b++) wd[b] = seqb[(w * MEM_W + b) % v.len];
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = AW'(w);
            wr_data = wd;
        end
        @(negedge clk);
        wr_en = 1'b0;

        total = (v.rot && v.dwl) ? 2 * v.steps : v.steps;
        nbits = 0;
        for (int q = 0; q < total; q++) begin
            int lg;
            lg = lag_of(v, q);
            for (int i = 0; i < v.len; i++) begin
                exb[nbits] = seqb[(lg + i) % v.len];
                nbits++;
            end
        end
        nwords = (nbits + OUT_W - 1) / OUT_W;
        for (int i = nbits; i < nwords * OUT_W; i++) exb[i] = 1'b0;
        for (int i = 0; i < nwords; i++) stepw[i] = 1'b0;
        for (int q = 1; q < total; q++)
            if (lag_of(v, q) != lag_of(v, q - 1)) stepw[(q * v.len) / OUT_W] = 1'b1;

        seq_len   = LW'(v.len);
        lag_count = LW'(v.steps);
        rot_en    = v.rot;
        dwell     = v.dwl;
        start     = 1'b1;
        en        = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        prev_en = 1'b1;
        k       = 0;
        cyc     = 0;
        while (k < nwords && cyc < 20000) begin
            if (!prev_en) // R9: no word after a stalled edge
                check(word_valid == 1'b0, "R9", "word during stall", 64'(word_valid), 64'(0));
            if (word_valid) begin
                for (int j = 0; j < OUT_W; j++) expw[j] = exb[k * OUT_W + j];
                check(word_out == expw, tg, $sformatf("word %0d", k), 64'(word_out), 64'(expw));
                check(trig_lag0 == (k == 0), "R6", $sformatf("start trigger word %0d", k),
                      64'(trig_lag0), 64'(k == 0));
                check(trig_step == stepw[k], "R7", $sformatf("step trigger word %0d", k),
                      64'(trig_step), 64'(stepw[k]));
                k++;
            end
            if (v.poke && cyc == 4) begin
                // R10: a start during a run with another configuration is ignored
                start     = 1'b1;
                seq_len   = LW'(OUT_W * 3);
                lag_count = LW'(1);
                rot_en    = 1'b0;
            end else begin
                start = 1'b0;
            end
            en      = v.stall ? ((cyc % 3) != 1) : 1'b1;
            prev_en = en;
            cyc++;
            @(negedge clk);
        end
        check(k == nwords, "R8", "words delivered", 64'(k), 64'(nwords));
        en    = 1'b1;
        start = 1'b0;
        check(busy == 1'b0, "R8", "busy after last word", 64'(busy), 64'(0));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(word_valid == 1'b0, "R8", "word after run end", 64'(word_valid), 64'(0));
        end
    endtask

    initial begin
        rst       = 1'b1;
        en        = 1'b0;
        start     = 1'b0;
        rot_en    = 1'b0;
        dwell     = 1'b0;
        seq_len   = '0;
        lag_count = '0;
        wr_en     = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        check(busy == 1'b0, "R11", "busy after reset", 64'(busy), 64'(0));
        check(word_valid == 1'b0, "R11", "valid after reset", 64'(word_valid), 64'(0));
        check(word_out == '0, "R11", "word after reset", 64'(word_out), 64'(0));
        check({trig_lag0, trig_step} == 2'b00, "R11", "triggers after reset",
              64'({trig_lag0, trig_step}), 64'(0));

        // R10: zero lag count is refused
        seq_len = LW'(20); lag_count = '0; rot_en = 1'b1; en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R10", "start with zero lags", 64'(busy), 64'(0));
        // R10: code shorter than one word is refused
        seq_len = LW'(OUT_W - 1); lag_count = LW'(3); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R10", "start with short code", 64'(busy), 64'(0));
        // R9: start while stalled is ignored
        seq_len = LW'(OUT_W); lag_count = LW'(3); en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R9", "start while stalled", 64'(busy), 64'(0));
        check(word_valid == 1'b0, "R9", "valid while stalled", 64'(word_valid), 64'(0));
        en = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 10; i++) run_vec(VECS[i]);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule